// File: doc/BRIEF.md
# Sampled Input Scale Unit

The scale unit is a small controller with a datapath. On each clock edge during an active burst it captures one of two 4-bit operands into an input register. On the same edge it writes a 5-bit scaled copy of the value that register held before into an output register. The scaled copy is the stored value doubled when that value is below an 8-bit limit, and the stored value divided by eight otherwise. Each active edge therefore pairs a capture with the result of the previous capture, so the output trails the input by one sample.

The controller has six states:
- `ST_CLEAR` zeroes both registers.
- `ST_IDLE` holds them while `active` is low.
- `ST_DBL_A`, `ST_DBL_B`, `ST_DIV_A` and `ST_DIV_B` cover the four pairings of source operand and scaling path.

The controller moves through these transitions:
- **clear-to-idle** is unconditional.
- **arm** goes from idle to an active state on the first edge with `active` high. It takes the source from `pick_a` and the path from comparing the stored value against `limit`.
- **continue** goes from one active state to another. It keeps the source and takes the path from comparing the operand being captured.
- **drop** returns from any active state to idle when `active` is low.
- A synchronous reset forces `ST_CLEAR` from any state.

Top module: `scale_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next `result` is 0 and the controller enters the clearing state.
- R2: The clearing state zeroes both registers and moves to idle on the following edge, whatever `active` is.
- R3: In idle with `active` low, `result` and the stored operand do not change.
- R4: The first edge with `active` high after idle captures nothing and leaves `result` unchanged; it fixes the source (`pick_a`=1 selects `opnd_a`, 0 selects `opnd_b`).
- R5: Every later edge with `active` still high captures the selected operand into the input register.
- R6: On such an edge, when the previously stored value, zero-extended, is below `limit` as an unsigned number, `result` becomes that value shifted left by one.
- R7: When the previously stored value is equal to or above `limit`, `result` becomes that value shifted right by three (an equal value takes this path).
- R8: `result` after each capture edge reflects the value stored before that edge. The first capture of a burst therefore outputs the scaled last sample of the previous burst, or 0 after clearing.
- R9: When `active` is low in an active state, the next edge returns to idle with `result` unchanged.
- R10: A change of `pick_a` during a burst is ignored; captures keep using the source fixed at arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 4 | Operand captured when the source is A |
| opnd_b | input | 4 | Operand captured when the source is B |
| limit | input | 8 | Unsigned threshold choosing double or divide; held steady within a burst |
| active | input | 1 | High to arm and run a sampling burst |
| pick_a | input | 1 | Source choice at arm: 1 = `opnd_a`, 0 = `opnd_b` |
| result | output | 5 | Scaled value of the previously stored operand |

## Verification
The capture of a new operand and the scaling of the old one fall on the same edge. An error in ordering them shows up as a result computed from the operand just presented instead of the one before. Each burst drives a different value on every cycle while the unselected operand carries the bitwise inverse. The expected output at each edge is computed from the value captured one edge earlier, so a lost, late or wrong-source capture gives a mismatch. The bursts mix values below, equal to and above the limit, so a path switch within a burst is also judged against the stored value.

// File: rtl/sisu_pkg.sv
package sisu_pkg;

    // Controller states: clear, idle, and source x path active states
    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,
        ST_IDLE  = 3'd1,
        ST_DBL_A = 3'd2,
        ST_DBL_B = 3'd3,
        ST_DIV_A = 3'd4,
        ST_DIV_B = 3'd5
    } sisu_state_e;

    // Datapath controls issued by the controller
    typedef struct packed {
        logic load;     // capture operand and update result
        logic clear;    // zero both registers
        logic src_b;    // 0 selects operand A, 1 selects operand B
        logic use_div;  // 1 selects the divide path
    } sisu_ctl_t;

endpackage

// File: rtl/sisu_cmp.sv
module sisu_cmp #(
    parameter int DW = 4,
    parameter int LW = 8
) (
    input  logic [DW-1:0] val,
    input  logic [LW-1:0] lim,
    output logic          below
);

    // Unsigned compare with the narrower side zero-extended
    generate
        if (LW > DW) begin : g_ext_val
            logic [LW-1:0] val_ext;
            assign val_ext = {{(LW-DW){1'b0}}, val};
            assign below   = (val_ext < lim);
        end else if (LW == DW) begin : g_same
            assign below = (val < lim);
        end else begin : g_ext_lim
            logic [DW-1:0] lim_ext;
            assign lim_ext = {{(DW-LW){1'b0}}, lim};
            assign below   = (val < lim_ext);
        end
    endgenerate

endmodule

// File: rtl/sisu_ctrl.sv
module sisu_ctrl
    import sisu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        pick_a,
    input  logic        below,
    output sisu_state_e state,
    output sisu_ctl_t   ctl
);

    sisu_state_e nxt;
    logic        cur_src_b;

    function automatic sisu_state_e pick_state(input logic use_b, input logic lo);
        if (lo) return use_b ? ST_DBL_B : ST_DBL_A;
        else    return use_b ? ST_DIV_B : ST_DIV_A;
    endfunction

    // Source fixed for the burst is encoded in the active state
    assign cur_src_b = (state == ST_DBL_B) || (state == ST_DIV_B);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_CLEAR;
        else     state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_CLEAR: nxt = ST_IDLE;
            ST_IDLE:  nxt = active ? pick_state(!pick_a, below) : ST_IDLE;
            ST_DBL_A,
            ST_DBL_B,
            ST_DIV_A,
            ST_DIV_B: nxt = active ? pick_state(cur_src_b, below) : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_CLEAR: ctl.clear = 1'b1;
            ST_IDLE:  ctl = '0;
            ST_DBL_A: begin ctl.load = active; ctl.src_b = 1'b0; ctl.use_div = 1'b0; end
            ST_DBL_B: begin ctl.load = active; ctl.src_b = 1'b1; ctl.use_div = 1'b0; end
            ST_DIV_A: begin ctl.load = active; ctl.src_b = 1'b0; ctl.use_div = 1'b1; end
            ST_DIV_B: begin ctl.load = active; ctl.src_b = 1'b1; ctl.use_div = 1'b1; end
            default:  ctl = '0;
        endcase
    end

endmodule

// File: rtl/sisu_datapath.sv
module sisu_datapath
    import sisu_pkg::*;
#(
    parameter int DW    = 4,
    parameter int LW    = 8,
    parameter int UP_SH = 1,
    parameter int DN_SH = 3,
    parameter int OW    = DW + UP_SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [LW-1:0] limit,
    input  sisu_ctl_t     ctl,
    output logic          below,
    output logic [OW-1:0] result
);

    logic [DW-1:0] in_q;
    logic [DW-1:0] pick_v;
    logic [DW-1:0] cmp_v;
    logic [OW-1:0] out_q;
    logic [OW-1:0] up_v;
    logic [OW-1:0] dn_v;
    logic [OW-1:0] nxt_out;

    // Operand mux
    assign pick_v = ctl.src_b ? opnd_b : opnd_a;

    // During a capture, compare the incoming operand; otherwise the stored one
    assign cmp_v = ctl.load ? pick_v : in_q;

    // Scaling paths
    assign up_v    = OW'(in_q) << UP_SH;
    assign dn_v    = OW'(in_q >> DN_SH);
    assign nxt_out = ctl.use_div ? dn_v : up_v;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (ctl.load) begin
            in_q  <= pick_v;
            out_q <= nxt_out;
        end
    end

    sisu_cmp #(.DW(DW), .LW(LW)) u_cmp (
        .val   (cmp_v),
        .lim   (limit),
        .below (below)
    );

    assign result = out_q;

endmodule

// File: rtl/scale_unit.sv
module scale_unit
    import sisu_pkg::*;
#(
    parameter int DW    = 4,
    parameter int LW    = 8,
    parameter int UP_SH = 1,
    parameter int DN_SH = 3,
    localparam int OW   = DW + UP_SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [LW-1:0] limit,
    input  logic          active,
    input  logic          pick_a,
    output logic [OW-1:0] result
);

    sisu_state_e st;
    sisu_ctl_t   ctl;
    logic        below;

    sisu_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .pick_a (pick_a),
        .below  (below),
        .state  (st),
        .ctl    (ctl)
    );

    sisu_datapath #(
        .DW(DW), .LW(LW), .UP_SH(UP_SH), .DN_SH(DN_SH), .OW(OW)
    ) u_dp (
        .clk    (clk),
        .rst    (rst),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .limit  (limit),
        .ctl    (ctl),
        .below  (below),
        .result (result)
    );

endmodule

// File: rtl/sisu_chk.sv
module sisu_chk
    import sisu_pkg::*;
#(
    parameter int DW    = 4,
    parameter int DN_SH = 3,
    parameter int OW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          active,
    input sisu_state_e   state,
    input sisu_ctl_t     ctl,
    input logic [OW-1:0] result
);

    localparam int DIV_MAX = ((1 << DW) - 1) >> DN_SH;

    logic in_act, in_dbl, in_div, src_a;
    assign in_dbl = (state == ST_DBL_A) || (state == ST_DBL_B);
    assign in_div = (state == ST_DIV_A) || (state == ST_DIV_B);
    assign in_act = in_dbl || in_div;
    assign src_a  = (state == ST_DBL_A) || (state == ST_DIV_A);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (result == '0 && state == ST_CLEAR));

    assert_clear_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |=> (state == ST_IDLE && result == '0));

    assert_ctl_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.load, ctl.clear}));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(result));

    assert_double_even_R6: assert property (@(posedge clk) disable iff (rst)
        (in_dbl && active) |=> (result[0] == 1'b0));

    assert_divide_small_R7: assert property (@(posedge clk) disable iff (rst)
        (in_div && active) |=> (result <= OW'(DIV_MAX)));

    assert_drop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (in_act && !active) |=> (state == ST_IDLE && $stable(result)));

    assert_source_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        (in_act && active) |=>
            (state == ST_IDLE || ((state == ST_DBL_A || state == ST_DIV_A) == $past(src_a))));

endmodule

bind scale_unit sisu_chk #(.DW(DW), .DN_SH(DN_SH), .OW(OW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .state  (st),
    .ctl    (ctl),
    .result (result)
);

// File: tb/scale_unit_test.sv
module scale_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opnd_a = '0;
    logic [3:0] opnd_b = '0;
    logic [7:0] limit = '0;
    logic       active = 1'b0;
    logic       pick_a = 1'b0;
    logic [4:0] result;

    int total = 0;
    int bad   = 0;

    logic [3:0] stored   = '0;
    logic [4:0] last_out = '0;

    always #2 clk = ~clk;

    scale_unit uut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .limit(limit), .active(active), .pick_a(pick_a), .result(result)
    );

    function automatic logic [4:0] scaled(input logic [3:0] v, input logic [7:0] l);
        if ({4'b0, v} < l) return {v, 1'b0};
        else               return {4'b0, v} >> 3;
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk) rst = 1'b1; active = 1'b0;
        edge_wait();
        check("R1 reset result", result, 5'd0);
        @(negedge clk) rst = 1'b0;
        edge_wait();
        check("R2 clear state result", result, 5'd0);
        stored = '0; last_out = '0;
    endtask

    // One burst: arm, four captures, drop, one idle edge
    task automatic t_burst(input logic use_a, input logic [7:0] lim,
                           input logic [15:0] vals, input logic flip);
        logic [4:0] exp;
        @(negedge clk) limit = lim; pick_a = use_a; active = 1'b1;
        opnd_a = 4'hF; opnd_b = 4'hA;
        edge_wait();
        check("R4 arm leaves result", result, last_out);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (use_a) begin opnd_a = vals[i*4 +: 4]; opnd_b = ~vals[i*4 +: 4]; end
            else       begin opnd_b = vals[i*4 +: 4]; opnd_a = ~vals[i*4 +: 4]; end
            if (flip && i >= 1) pick_a = ~use_a;
            exp = scaled(stored, lim);
            edge_wait();
            if (flip && i >= 2)
                check("R10 source kept", result, exp);
            else if ({4'b0, stored} < lim)
                check("R5 R6 R8 double prior", result, exp);
            else
                check("R5 R7 R8 divide prior", result, exp);
            stored = vals[i*4 +: 4];
            last_out = exp;
        end
        @(negedge clk) active = 1'b0; pick_a = use_a; opnd_a = 4'h9; opnd_b = 4'h6;
        edge_wait();
        check("R9 drop holds", result, last_out);
        @(negedge clk) opnd_a = 4'h3; opnd_b = 4'hC;
        edge_wait();
        check("R3 idle holds", result, last_out);
    endtask

    task automatic t_reset_mid();
        @(negedge clk) limit = 8'd8; pick_a = 1'b1; active = 1'b1; opnd_a = 4'd5;
        edge_wait();
        @(negedge clk) opnd_a = 4'd7;
        edge_wait();
        @(negedge clk) rst = 1'b1; active = 1'b0;
        edge_wait();
        check("R1 reset mid burst", result, 5'd0);
        @(negedge clk) rst = 1'b0; active = 1'b1;
        edge_wait();
        check("R2 clear ignores active", result, 5'd0);
        @(negedge clk) active = 1'b0;
        edge_wait();
        stored = '0; last_out = '0;
        // Next burst must start from cleared value
        t_burst(1'b1, 8'd8, {4'd4, 4'd4, 4'd2, 4'd9}, 1'b0);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        edge_wait();
        edge_wait();
        check("R1 initial reset", result, 5'd0);
        @(negedge clk) rst = 1'b0;
        edge_wait();
        check("R2 initial clear", result, 5'd0);
        // values listed from last to first: vals[3:0] is the first capture
        t_burst(1'b1, 8'd8,   {4'd1, 4'd7, 4'd5, 4'd3},   1'b0);
        t_burst(1'b0, 8'd8,   {4'd12, 4'd9, 4'd15, 4'd8}, 1'b0);
        t_burst(1'b1, 8'd6,   {4'd2, 4'd14, 4'd5, 4'd6},  1'b1);
        t_burst(1'b0, 8'd255, {4'd4, 4'd15, 4'd0, 4'd15}, 1'b1);
        t_burst(1'b1, 8'd0,   {4'd0, 4'd7, 4'd8, 4'd15},  1'b0);
        t_reset_mid();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule